// File: doc/BRIEF.md
# Critical Section Request Buffer

This block sits between a group of small cores and a single large core that runs critical sections for them. When a small core reaches a critical section, it does not run the section itself. It posts a call request that carries a lock identifier and the start address of the section. The buffer queues these calls and offers them to the large core one at a time. When the large core reports that a call has finished, the buffer sends a one-cycle done pulse back to the core that issued it. That core stays stalled until the pulse arrives.

Each small core has its own request port, and the port index is the core's identity. The request side and the service side are both valid/ready streams. A request is taken on a cycle where `req_valid[i]` and `req_ready[i]` are both high. While `req_ready[i]` is low, a core must hold its request or withdraw it. Nothing is taken from it in that state. On the service side, an entry leaves the queue on a cycle where `srv_valid` and `srv_ready` are both high. `srv_valid` only asserts when no entry is in service. Completion is a plain pulse, `done_in`, from the large core. The queue depth equals the number of cores, and each core has at most one call outstanding, so the queue cannot overflow.

Top module: `cs_req_buffer`

## Requirements
- R1: After reset, `srv_valid` is low, `done_out` is all zeros, and every bit of `req_ready` is high.
- R2: A request taken from port i is later offered on the service port with `srv_core` equal to i and with the lock and address that were presented at the moment it was taken.
- R3: Requests taken in different cycles are offered to the large core in the order they were taken.
- R4: When several requests are taken in the same cycle, the one on the lower port index is offered first.
- R5: After a request from port i is taken, `req_ready[i]` stays low until the done pulse for that call. A `req_valid[i]` asserted in that window is not queued.
- R6: While the queue holds as many entries as there are cores, every bit of `req_ready` is low, and the fill never exceeds the core count.
- R7: After a service handshake, `srv_valid` stays low until the cycle after `done_in` is pulsed. Only one entry is ever in service.
- R8: One cycle after `done_in` is sampled high during service, `done_out` pulses for exactly one cycle. The pulse is on the bit given by the core ID stored with the entry in service. A `done_in` sampled while nothing is in service produces no pulse.
- R9: In the cycle of its done pulse, `req_ready[i]` is high again, so that core can post its next call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Call request valid, one bit per small core |
| req_lock | input | NUM_CORES*LOCK_W | Lock identifier per core, core i in slice i |
| req_addr | input | NUM_CORES*ADDR_W | Critical-section start address per core, core i in slice i |
| req_ready | output | NUM_CORES | Request may be taken from this core |
| srv_valid | output | 1 | An entry is offered to the large core |
| srv_ready | input | 1 | Large core takes the offered entry |
| srv_core | output | ID_W | Requesting core of the offered entry |
| srv_lock | output | LOCK_W | Lock identifier of the offered entry |
| srv_addr | output | ADDR_W | Start address of the offered entry |
| done_in | input | 1 | Large core finished the entry in service (pulse) |
| done_out | output | NUM_CORES | One-cycle completion pulse, one bit per small core |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives while the same core's earlier call is still pending. The second is a queue that is completely full. A full queue can only happen when every core has posted a call and the large core has taken none of them. The stimulus reaches it by raising all request lines in one cycle and holding `srv_ready` low, then checking that every ready is low and that the drain order follows port index. For the hold-off case, a core re-asserts its request while its call is queued. The bench then drains the queue and checks that no extra entry is ever offered.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

  typedef enum logic {
    SVC_IDLE = 1'b0,
    SVC_BUSY = 1'b1
  } svc_state_e;

endpackage

// File: rtl/csrb_admit.sv
module csrb_admit #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] req_valid,
  input  logic [NUM_CORES-1:0] pending,
  input  logic                 full,
  output logic [NUM_CORES-1:0] req_ready,
  output logic [NUM_CORES-1:0] grant
);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_port
    assign req_ready[i] = !pending[i] && !full;
    assign grant[i]     = req_valid[i] && req_ready[i];
  end

endmodule

// File: rtl/csrb_fifo.sv
module csrb_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] wr_en,
  input  logic [DEPTH*W-1:0] wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     head,
  output logic             head_valid,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = ((PW > CW) ? PW : CW) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] rank [DEPTH];
  logic [PW-1:0] slot [DEPTH];
  logic [CW-1:0] n_wr;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] base,
                                             input logic [CW-1:0] off);
    logic [SW-1:0] s;
    s = SW'(base) + SW'(off);
    if (s >= SW'(DEPTH)) s = s - SW'(DEPTH);
    return s[PW-1:0];
  endfunction

  always_comb begin
    logic [CW-1:0] run;
    run = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = run;
      slot[i] = wrap_add(wr_ptr, run);
      run     = run + CW'(wr_en[i]);
    end
    n_wr = run;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) mem[slot[i]] <= wr_data[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wrap_add(wr_ptr, n_wr);
      if (rd_en) rd_ptr <= wrap_add(rd_ptr, CW'(1));
      fill   <= fill + n_wr - CW'(rd_en);
    end
  end

  assign head       = mem[rd_ptr];
  assign head_valid = (fill != '0);
  assign full       = (fill == CW'(DEPTH));

endmodule

// File: rtl/csrb_svc.sv
module csrb_svc #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 head_valid,
  input  logic [ID_W-1:0]      head_core,
  input  logic                 srv_ready,
  input  logic                 done_in,
  output logic                 srv_valid,
  output logic                 pop,
  output logic [NUM_CORES-1:0] release_vec,
  output logic [NUM_CORES-1:0] done_out
);

  import csrb_pkg::*;

  svc_state_e      state;
  logic [ID_W-1:0] cur_core;

  assign srv_valid = head_valid && (state == SVC_IDLE);
  assign pop       = srv_valid && srv_ready;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_rel
    assign release_vec[i] = (state == SVC_BUSY) && done_in && (cur_core == ID_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SVC_IDLE;
      cur_core <= '0;
      done_out <= '0;
    end else begin
      done_out <= release_vec;
      if (pop) begin
        state    <= SVC_BUSY;
        cur_core <= head_core;
      end else if (state == SVC_BUSY && done_in) begin
        state <= SVC_IDLE;
      end
    end
  end

endmodule

// File: rtl/cs_req_buffer.sv
module cs_req_buffer #(
  parameter int NUM_CORES = 4,
  parameter int LOCK_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  input  logic [NUM_CORES*LOCK_W-1:0] req_lock,
  input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
  output logic [NUM_CORES-1:0]        req_ready,
  output logic                        srv_valid,
  input  logic                        srv_ready,
  output logic [ID_W-1:0]             srv_core,
  output logic [LOCK_W-1:0]           srv_lock,
  output logic [ADDR_W-1:0]           srv_addr,
  input  logic                        done_in,
  output logic [NUM_CORES-1:0]        done_out
);

  localparam int EW = ID_W + LOCK_W + ADDR_W;
  localparam int CW = $clog2(NUM_CORES+1);

  logic [NUM_CORES-1:0]    pending;
  logic [NUM_CORES-1:0]    grant;
  logic [NUM_CORES-1:0]    release_vec;
  logic                    full;
  logic                    head_valid;
  logic                    pop;
  logic [EW-1:0]           head;
  logic [NUM_CORES*EW-1:0] wr_data;
  logic [CW-1:0]           fill_cnt;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_pack
    assign wr_data[i*EW +: EW] = {ID_W'(i), req_lock[i*LOCK_W +: LOCK_W],
                                  req_addr[i*ADDR_W +: ADDR_W]};
  end

  csrb_admit #(.NUM_CORES(NUM_CORES)) admit_i (
    .req_valid (req_valid),
    .pending   (pending),
    .full      (full),
    .req_ready (req_ready),
    .grant     (grant)
  );

  csrb_fifo #(.DEPTH(NUM_CORES), .W(EW)) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (grant),
    .wr_data    (wr_data),
    .rd_en      (pop),
    .head       (head),
    .head_valid (head_valid),
    .full       (full),
    .fill       (fill_cnt)
  );

  csrb_svc #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) svc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (head_valid),
    .head_core   (head[EW-1 -: ID_W]),
    .srv_ready   (srv_ready),
    .done_in     (done_in),
    .srv_valid   (srv_valid),
    .pop         (pop),
    .release_vec (release_vec),
    .done_out    (done_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending | grant) & ~release_vec;
  end

  assign srv_core = head[EW-1 -: ID_W];
  assign srv_lock = head[ADDR_W +: LOCK_W];
  assign srv_addr = head[ADDR_W-1:0];

endmodule

// File: rtl/cs_req_buffer_chk.sv
module cs_req_buffer_chk #(
  parameter int NUM_CORES = 4,
  parameter int CW        = $clog2(NUM_CORES+1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] req_valid,
  input logic [NUM_CORES-1:0] req_ready,
  input logic                 srv_valid,
  input logic                 srv_ready,
  input logic                 done_in,
  input logic [NUM_CORES-1:0] done_out,
  input logic [CW-1:0]        fill
);

  a_r8_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_out));

  a_r8_done_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (done_out != '0) |-> $past(done_in));

  a_r7_single_service: assert property (@(posedge clk) disable iff (!rst_n)
    (srv_valid && srv_ready) |=> !srv_valid);

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(NUM_CORES)) |-> (req_ready == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(NUM_CORES));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_hold
    a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i]) |=> !req_ready[i]);
  end

endmodule

bind cs_req_buffer cs_req_buffer_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .srv_valid (srv_valid),
  .srv_ready (srv_ready),
  .done_in   (done_in),
  .done_out  (done_out),
  .fill      (fill_cnt)
);

// File: tb/cs_req_buffer_tb_top.sv
module cs_req_buffer_tb_top;

  localparam int N = 4;
  localparam int LW = 8;
  localparam int AW = 32;
  localparam int IW = 2;

  typedef struct {
    int          core;
    logic [LW-1:0] lock;
    logic [AW-1:0] addr;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*LW-1:0] req_lock = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    req_ready;
  logic            srv_valid;
  logic            srv_ready = 1'b0;
  logic [IW-1:0]   srv_core;
  logic [LW-1:0]   srv_lock;
  logic [AW-1:0]   srv_addr;
  logic            done_in = 1'b0;
  logic [N-1:0]    done_out;

  int total = 0;
  int bad = 0;
  int serial = 0;
  logic [N-1:0] pend = '0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  cs_req_buffer #(.NUM_CORES(N), .LOCK_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lock(req_lock),
    .req_addr(req_addr), .req_ready(req_ready), .srv_valid(srv_valid),
    .srv_ready(srv_ready), .srv_core(srv_core), .srv_lock(srv_lock),
    .srv_addr(srv_addr), .done_in(done_in), .done_out(done_out)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, presents requests for one cycle
  task automatic issue(input logic [N-1:0] mask);
    for (int i = 0; i < N; i++) begin
      serial++;
      req_lock[i*LW +: LW] = LW'(8'h10 + i + serial);
      req_addr[i*AW +: AW] = 32'hA000_0000 + AW'(i * 16) + AW'(serial);
    end
    check(req_ready == ~pend, "R5 ready before issue", 64'(req_ready), 64'(~pend));
    req_valid = mask;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && !pend[i]) begin
        item_t it;
        it.core = i;
        it.lock = req_lock[i*LW +: LW];
        it.addr = req_addr[i*AW +: AW];
        exp_q.push_back(it);
      end
    end
    @(posedge clk);
    @(negedge clk);
    pend = pend | mask;
    req_valid = '0;
    for (int i = 0; i < N; i++)
      if (mask[i]) check(!req_ready[i], "R5 ready low after take", 64'(req_ready[i]), 64'd0);
  endtask

  // monitor / large core: takes the head, compares it, completes it
  task automatic serve();
    item_t e;
    check(srv_valid == 1'b1 && exp_q.size() > 0, "R2 entry offered",
          64'(srv_valid), 64'd1);
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    check(int'(srv_core) == e.core, "R2/R3/R4 core order", 64'(srv_core), 64'(e.core));
    check(srv_lock == e.lock, "R2 lock", 64'(srv_lock), 64'(e.lock));
    check(srv_addr == e.addr, "R2 addr", 64'(srv_addr), 64'(e.addr));
    srv_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    srv_ready = 1'b0;
    check(!srv_valid, "R7 no offer during service", 64'(srv_valid), 64'd0);
    @(negedge clk);
    check(!srv_valid, "R7 still in service", 64'(srv_valid), 64'd0);
    check(done_out == '0, "R8 no early done", 64'(done_out), 64'd0);
    done_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done_in = 1'b0;
    check(done_out == N'(1 << e.core), "R8 done routed", 64'(done_out), 64'(1 << e.core));
    check(req_ready[e.core], "R9 ready back", 64'(req_ready[e.core]), 64'd1);
    pend[e.core] = 1'b0;
    @(negedge clk);
    check(done_out == '0, "R8 one-cycle pulse", 64'(done_out), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!srv_valid, "R1 srv_valid", 64'(srv_valid), 64'd0);
    check(done_out == '0, "R1 done_out", 64'(done_out), 64'd0);
    check(req_ready == '1, "R1 req_ready", 64'(req_ready), 64'hF);

    // single call from core 2
    issue(4'b0100);
    serve();

    // R8: done_in with nothing in service
    done_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done_in = 1'b0;
    check(done_out == '0, "R8 idle done ignored", 64'(done_out), 64'd0);

    // R4: simultaneous cores 3,1,0 -> 0,1,3
    issue(4'b1011);
    repeat (3) serve();

    // R3: core 3 then core 0 in later cycle
    issue(4'b1000);
    issue(4'b0001);
    serve();
    serve();

    // R6: all cores at once, queue full
    issue(4'b1111);
    check(req_ready == '0, "R6 full blocks all", 64'(req_ready), 64'd0);
    repeat (4) serve();

    // R5: re-request while pending is not queued
    issue(4'b0010);
    req_valid = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    serve();
    check(!srv_valid, "R5 no duplicate queued", 64'(srv_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule